// File: doc/BRIEF.md
# Configurable Output Macrocell Array

This block is the output stage of a small sum-of-products programmable logic device. Eight macrocells sit behind eight bidirectional pins. Each macrocell takes a finished sum term and a product term for its output enable from the logic array. It drives a pin value and a tristate enable, and it returns one feedback bit to the array. Two more pins, a clock pin and an active-low enable pin, either serve those roles or act as plain inputs. Which one depends on the global mode.

An 18-bit static configuration sets the behaviour. Two global bits, `cfg_syn_i` and `cfg_ac0_i`, pick one of three modes for the whole array. Each macrocell also has two bits of its own: an inversion bit and a direction bit. Together these decide whether an output is registered or combinational, where its enable comes from, and which pin or register feeds the array through its feedback line. The registers run on the block clock `clk_i`. In registered mode they capture only on cycles when the clock pin input is high. A synchronous reset clears them, and a preload path can write them directly.

Macrocell index i stands for pin 19−i. Index 0 and index 7 are the outermost pins (19 and 12). Indices 3 and 4 are the innermost pins (16 and 15).

Top module: `olmc_array`

## Requirements
- R1: The global bits select the mode for every macrocell. `cfg_syn_i`=0 selects registered mode, `cfg_syn_i`=1 with `cfg_ac0_i`=1 selects complex mode, and `cfg_syn_i`=1 with `cfg_ac0_i`=0 selects simple mode.
- R2: In registered mode, a macrocell with direction bit 0 is registered. At a rising `clk_i` edge with `pin_ck_i`=1 its register captures `sop_i[i]`. With `pin_ck_i`=0 the register holds.
- R3: In registered mode, every registered macrocell's enable equals the inverse of `pin_oe_n_i`.
- R4: A registered macrocell feeds back the inverse of its register contents.
- R5: In registered mode, a macrocell with direction bit 1 is combinational. It drives `sop_i[i]` XOR its inversion bit, takes its enable from `oe_term_i[i]`, and feeds back `pin_in_i[i]`.
- R6: In complex mode, a macrocell with direction bit 0 is combinational and takes its enable from `oe_term_i[i]`. Macrocell 0 feeds back `pin_ck_i`, macrocell 7 feeds back `pin_oe_n_i`, and every other macrocell feeds back its own pin.
- R7: In complex or simple mode, a macrocell with direction bit 1 is an input. Its enable is 0 and its driven value is 0. Innermost cells in simple mode are excepted (R9).
- R8: In simple mode, an output macrocell is always enabled whatever `oe_term_i` holds, and it drives `sop_i[i]` XOR its inversion bit.
- R9: In simple mode, macrocells 0 to 2 feed back pin i+1 and macrocells 5 to 7 feed back pin i−1. Macrocells 3 and 4 feed back 0 and stay enabled outputs even when their direction bit is 1.
- R10: A synchronous reset clears all registers. Registered macrocells then drive their inversion bit and feed back 1.
- R11: `preload_i` loads `preload_d_i` into all registers at the next edge, in any mode. It takes priority over a capture.
- R12: A set inversion bit inverts the driven value in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_syn_i | input | 1 | Global mode bit, 0 selects registered mode |
| cfg_ac0_i | input | 1 | Global mode bit, selects complex over simple |
| cfg_inv_i | input | 8 | Per-macrocell output inversion |
| cfg_ac1_i | input | 8 | Per-macrocell direction bit |
| sop_i | input | 8 | Sum-of-products result per macrocell |
| oe_term_i | input | 8 | Enable product term per macrocell |
| pin_ck_i | input | 1 | Clock pin: capture qualifier or plain input |
| pin_oe_n_i | input | 1 | Enable pin: shared active-low enable or plain input |
| pin_in_i | input | 8 | Values present on the I/O pins |
| preload_i | input | 1 | Load registers from preload data |
| preload_d_i | input | 8 | Preload data |
| pin_out_o | output | 8 | Driven pin values |
| pin_oe_o | output | 8 | Tristate enables, 1 drives the pin |
| fb_o | output | 8 | Feedback lines into the array |

## Verification
Almost every path here is combinational from the configuration to the ports. A wrong decode therefore shows in the same cycle as a wrong enable, a wrong driven value or a wrong feedback line. The checks set input patterns whose bits differ between the candidate sources, so a misrouted feedback line exposes the bit it picked. A corrupted register shows one edge after the capture, preload or reset that should have set it. It shows twice, on `pin_out_o` and inverted on `fb_o`. A register that captures while the clock pin is low shows after the first hold cycle.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

    localparam int unsigned NCELL_DEF = 8;

    typedef enum logic [1:0] {
        MODE_SIMPLE     = 2'd0,
        MODE_COMPLEX    = 2'd1,
        MODE_REGISTERED = 2'd2
    } gmode_e;

    typedef enum logic [1:0] {
        CELL_REG     = 2'd0,
        CELL_COMB_PT = 2'd1,
        CELL_COMB_ON = 2'd2,
        CELL_INPUT   = 2'd3
    } cell_kind_e;

    typedef enum logic [2:0] {
        FB_NONE = 3'd0,
        FB_QN   = 3'd1,
        FB_SELF = 3'd2,
        FB_NEXT = 3'd3,
        FB_PREV = 3'd4,
        FB_CK   = 3'd5,
        FB_OEN  = 3'd6
    } fb_src_e;

    typedef struct packed {
        cell_kind_e kind;
        fb_src_e    fb;
        logic       inv;
    } cell_cfg_t;

    function automatic gmode_e decode_mode(input logic syn, input logic ac0);
        if (!syn)
            return MODE_REGISTERED;
        return ac0 ? MODE_COMPLEX : MODE_SIMPLE;
    endfunction

    function automatic cell_cfg_t cell_decode(input gmode_e m, input logic ac1,
                                              input logic inv, input int unsigned idx,
                                              input int unsigned n);
        cell_cfg_t c;
        logic      inner;
        inner = (idx == n/2 - 1) || (idx == n/2);
        c.inv  = inv;
        c.kind = CELL_INPUT;
        c.fb   = FB_SELF;
        case (m)
            MODE_REGISTERED: begin
                c.kind = ac1 ? CELL_COMB_PT : CELL_REG;
                c.fb   = ac1 ? FB_SELF : FB_QN;
            end
            MODE_COMPLEX: begin
                c.kind = ac1 ? CELL_INPUT : CELL_COMB_PT;
                if (idx == 0)
                    c.fb = FB_CK;
                else if (idx == n - 1)
                    c.fb = FB_OEN;
                else
                    c.fb = FB_SELF;
            end
            default: begin
                if (inner) begin
                    c.kind = CELL_COMB_ON;
                    c.fb   = FB_NONE;
                end else begin
                    c.kind = ac1 ? CELL_INPUT : CELL_COMB_ON;
                    c.fb   = (idx < n/2) ? FB_NEXT : FB_PREV;
                end
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/olmc_mode_dec.sv
module olmc_mode_dec
    import olmc_pkg::*;
#(
    parameter int unsigned N_CELLS = NCELL_DEF
) (
    input  logic                          syn_i,
    input  logic                          ac0_i,
    input  logic [N_CELLS-1:0]            inv_i,
    input  logic [N_CELLS-1:0]            ac1_i,
    output gmode_e                        mode_o,
    output cell_cfg_t [N_CELLS-1:0]       cell_o
);

    assign mode_o = decode_mode(syn_i, ac0_i);

    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        assign cell_o[g] = cell_decode(mode_o, ac1_i[g], inv_i[g], g, N_CELLS);
    end

endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
    import olmc_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      cap_en_i,
    input  logic      preload_i,
    input  logic      preload_d_i,
    input  cell_cfg_t cfg_i,
    input  logic      sop_i,
    input  logic      oe_term_i,
    input  logic      pin_oe_n_i,
    output logic      pin_out_o,
    output logic      pin_oe_o,
    output logic      q_n_o
);

    logic q_r;
    logic cap_here;

    assign cap_here = cap_en_i && (cfg_i.kind == CELL_REG);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            q_r <= 1'b0;
        else if (preload_i)
            q_r <= preload_d_i;
        else if (cap_here)
            q_r <= sop_i;
    end

    assign q_n_o = ~q_r;

    always_comb begin
        pin_out_o = 1'b0;
        pin_oe_o  = 1'b0;
        case (cfg_i.kind)
            CELL_REG: begin
                pin_out_o = q_r ^ cfg_i.inv;
                pin_oe_o  = ~pin_oe_n_i;
            end
            CELL_COMB_PT: begin
                pin_out_o = sop_i ^ cfg_i.inv;
                pin_oe_o  = oe_term_i;
            end
            CELL_COMB_ON: begin
                pin_out_o = sop_i ^ cfg_i.inv;
                pin_oe_o  = 1'b1;
            end
            default: begin
                pin_out_o = 1'b0;
                pin_oe_o  = 1'b0;
            end
        endcase
    end

    AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!preload_i && !cap_en_i) |=> $stable(q_r));  // R2
    AST_PRELOAD_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        preload_i |=> (q_r == $past(preload_d_i)));  // R11
    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (q_r == 1'b0));  // R10

endmodule

// File: rtl/olmc_fb_route.sv
module olmc_fb_route
    import olmc_pkg::*;
#(
    parameter int unsigned N_CELLS = NCELL_DEF
) (
    input  cell_cfg_t [N_CELLS-1:0] cell_i,
    input  logic [N_CELLS-1:0]      q_n_i,
    input  logic [N_CELLS-1:0]      pin_in_i,
    input  logic                    pin_ck_i,
    input  logic                    pin_oe_n_i,
    output logic [N_CELLS-1:0]      fb_o
);

    for (genvar g = 0; g < N_CELLS; g++) begin : g_fb
        localparam int unsigned NXT = (g < N_CELLS - 1) ? g + 1 : g;
        localparam int unsigned PRV = (g > 0) ? g - 1 : g;
        always_comb begin
            case (cell_i[g].fb)
                FB_QN:   fb_o[g] = q_n_i[g];
                FB_SELF: fb_o[g] = pin_in_i[g];
                FB_NEXT: fb_o[g] = pin_in_i[NXT];
                FB_PREV: fb_o[g] = pin_in_i[PRV];
                FB_CK:   fb_o[g] = pin_ck_i;
                FB_OEN:  fb_o[g] = pin_oe_n_i;
                default: fb_o[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/olmc_array.sv
module olmc_array
    import olmc_pkg::*;
#(
    parameter int unsigned N_CELLS = NCELL_DEF
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               cfg_syn_i,
    input  logic               cfg_ac0_i,
    input  logic [N_CELLS-1:0] cfg_inv_i,
    input  logic [N_CELLS-1:0] cfg_ac1_i,
    input  logic [N_CELLS-1:0] sop_i,
    input  logic [N_CELLS-1:0] oe_term_i,
    input  logic               pin_ck_i,
    input  logic               pin_oe_n_i,
    input  logic [N_CELLS-1:0] pin_in_i,
    input  logic               preload_i,
    input  logic [N_CELLS-1:0] preload_d_i,
    output logic [N_CELLS-1:0] pin_out_o,
    output logic [N_CELLS-1:0] pin_oe_o,
    output logic [N_CELLS-1:0] fb_o
);

    localparam int unsigned IN_LO = N_CELLS/2 - 1;
    localparam int unsigned IN_HI = N_CELLS/2;

    gmode_e                  mode;
    cell_cfg_t [N_CELLS-1:0] cell_cfg;
    logic [N_CELLS-1:0]      q_n;
    logic                    cap_en;

    olmc_mode_dec #(.N_CELLS(N_CELLS)) u_dec (
        .syn_i  (cfg_syn_i),
        .ac0_i  (cfg_ac0_i),
        .inv_i  (cfg_inv_i),
        .ac1_i  (cfg_ac1_i),
        .mode_o (mode),
        .cell_o (cell_cfg)
    );

    assign cap_en = (mode == MODE_REGISTERED) && pin_ck_i;

    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        olmc_cell u_cell (
            .clk_i       (clk_i),
            .rst_i       (rst_i),
            .cap_en_i    (cap_en),
            .preload_i   (preload_i),
            .preload_d_i (preload_d_i[g]),
            .cfg_i       (cell_cfg[g]),
            .sop_i       (sop_i[g]),
            .oe_term_i   (oe_term_i[g]),
            .pin_oe_n_i  (pin_oe_n_i),
            .pin_out_o   (pin_out_o[g]),
            .pin_oe_o    (pin_oe_o[g]),
            .q_n_o       (q_n[g])
        );

        AST_REG_OE_SHARED: assert property (@(posedge clk_i) disable iff (rst_i)
            (!cfg_syn_i && !cfg_ac1_i[g]) |-> (pin_oe_o[g] == !pin_oe_n_i));  // R3
    end

    olmc_fb_route #(.N_CELLS(N_CELLS)) u_route (
        .cell_i     (cell_cfg),
        .q_n_i      (q_n),
        .pin_in_i   (pin_in_i),
        .pin_ck_i   (pin_ck_i),
        .pin_oe_n_i (pin_oe_n_i),
        .fb_o       (fb_o)
    );

    AST_INNER_NO_FB: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_syn_i && !cfg_ac0_i) |-> (!fb_o[IN_LO] && !fb_o[IN_HI]));  // R9
    AST_INNER_ALWAYS_ON: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_syn_i && !cfg_ac0_i) |-> (pin_oe_o[IN_LO] && pin_oe_o[IN_HI]));  // R9

endmodule

// File: tb/olmc_array_bench.sv
module olmc_array_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       syn, ac0;
    logic [7:0] inv, ac1, sop, oet, pin_in, pl_d;
    logic       pck, poen, pl;
    logic [7:0] pout, poe, fb;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    olmc_array u_olmc_array (
        .clk_i       (clk),
        .rst_i       (rst),
        .cfg_syn_i   (syn),
        .cfg_ac0_i   (ac0),
        .cfg_inv_i   (inv),
        .cfg_ac1_i   (ac1),
        .sop_i       (sop),
        .oe_term_i   (oet),
        .pin_ck_i    (pck),
        .pin_oe_n_i  (poen),
        .pin_in_i    (pin_in),
        .preload_i   (pl),
        .preload_d_i (pl_d),
        .pin_out_o   (pout),
        .pin_oe_o    (poe),
        .fb_o        (fb)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] simple_fb(input logic [7:0] p);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < 3; i++) r[i] = p[i+1];
        for (int i = 5; i < 8; i++) r[i] = p[i-1];
        return r;
    endfunction

    task automatic edge_settle();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; syn = 1'b0; ac0 = 1'b0; inv = 8'h00; ac1 = 8'h00;
        pck = 1'b1; poen = 1'b0; sop = 8'hFF; pl = 1'b0;
        edge_settle();
        @(negedge clk); rst = 1'b0; pck = 1'b0; #1;
        check("R10 reset out", pout, 8'h00);
        check("R4 reset fb", fb, 8'hFF);
        check("R3 reset oe", poe, 8'hFF);
    endtask

    task automatic t_reg_capture();
        @(negedge clk);
        inv = 8'h0F; pck = 1'b1; sop = 8'hA5;
        edge_settle();
        check("R2 capture out / R12", pout, 8'hA5 ^ 8'h0F);
        check("R4 capture fb", fb, ~8'hA5);
        @(negedge clk); pck = 1'b0; sop = 8'h3C;
        edge_settle();
        check("R2 hold with clock pin low", pout, 8'hA5 ^ 8'h0F);
        check("R1 registered mode selected", fb, ~8'hA5);
    endtask

    task automatic t_reg_oe();
        @(negedge clk); poen = 1'b1; #1;
        check("R3 enable pin high", poe, 8'h00);
        @(negedge clk); poen = 1'b0; #1;
        check("R3 enable pin low", poe, 8'hFF);
    endtask

    task automatic t_reg_comb();
        @(negedge clk);
        ac1 = 8'h81; inv = 8'h80; sop = 8'h81; oet = 8'h01; pin_in = 8'h80; poen = 1'b0; #1;
        check("R5 comb value", pout & 8'h81, (8'h81 ^ 8'h80) & 8'h81);
        check("R5 comb enable", poe, 8'h7F);
        check("R5 comb fb", fb & 8'h81, 8'h80);
        ac1 = 8'h00; inv = 8'h00;
    endtask

    task automatic t_preload();
        @(negedge clk); pl = 1'b1; pl_d = 8'h3C; pck = 1'b0;
        edge_settle();
        check("R11 preload clock pin low", pout, 8'h3C);
        @(negedge clk); pck = 1'b1; sop = 8'hF0; pl_d = 8'h5A;
        edge_settle();
        check("R11 preload over capture", pout, 8'h5A);
        @(negedge clk); pl = 1'b0; pck = 1'b0;
        syn = 1'b1; ac0 = 1'b1; pl = 1'b1; pl_d = 8'hC3;
        edge_settle();
        @(negedge clk); pl = 1'b0; syn = 1'b0; #1;
        check("R11 preload in complex mode", fb, ~8'hC3);
    endtask

    task automatic t_complex();
        @(negedge clk);
        syn = 1'b1; ac0 = 1'b1; ac1 = 8'h00; inv = 8'h11;
        sop = 8'h96; oet = 8'h5A; pin_in = 8'hB6; pck = 1'b1; poen = 1'b0; #1;
        check("R6 complex value / R12", pout, 8'h96 ^ 8'h11);
        check("R6 complex enable", poe, 8'h5A);
        check("R6 complex fb", fb, {1'b0, 6'b011011, 1'b1});
        @(negedge clk); pck = 1'b0; poen = 1'b1; #1;
        check("R6 edge pins fb", fb & 8'h81, 8'h80);
    endtask

    task automatic t_complex_input();
        @(negedge clk);
        ac1 = 8'h24; oet = 8'hFF; sop = 8'hFF; inv = 8'h00; #1;
        check("R7 complex input enable", poe, 8'hDB);
        check("R7 complex input value", pout, 8'hDB);
        check("R7 complex input fb", fb & 8'h24, pin_in & 8'h24);
    endtask

    task automatic t_simple();
        @(negedge clk);
        syn = 1'b1; ac0 = 1'b0; ac1 = 8'h00; inv = 8'h0F;
        sop = 8'h66; oet = 8'h00; pin_in = 8'hB6; #1;
        check("R8 simple enable", poe, 8'hFF);
        check("R8 simple value / R12", pout, 8'h66 ^ 8'h0F);
        check("R9 simple fb", fb, simple_fb(8'hB6));
        @(negedge clk); pin_in = 8'h49; #1;
        check("R9 simple fb second pattern", fb, simple_fb(8'h49));
    endtask

    task automatic t_simple_inner();
        @(negedge clk);
        ac1 = 8'hFF; inv = 8'h00; sop = 8'hFF; #1;
        check("R9 inner stay enabled / R7", poe, 8'h18);
        check("R9 inner value", pout, 8'h18);
        check("R9 inner fb zero", fb & 8'h18, 8'h00);
    endtask

    initial begin
        rst = 1'b1; syn = 1'b0; ac0 = 1'b0; inv = 8'h00; ac1 = 8'h00;
        sop = 8'h00; oet = 8'h00; pck = 1'b0; poen = 1'b0;
        pin_in = 8'h00; pl = 1'b0; pl_d = 8'h00;
        repeat (2) @(posedge clk);
        t_reset();
        t_reg_capture();
        t_reg_oe();
        t_reg_comb();
        t_preload();
        t_complex();
        t_complex_input();
        t_simple();
        t_simple_inner();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule